// File: doc/BRIEF.md
# Streaming Keyword Matcher

This block scans a byte stream for a set of keywords held in on-chip registers. Each stored character occupies one column of a compare array. A per-column end mark closes a keyword. Every accepted input byte is compared against all columns in the same cycle. The column results feed a chain of processing elements, one per column. Each element keeps a single flag. The flag means that the keyword prefix ending at this column has just appeared in the stream.

When the flag of an end-marked column is set, a keyword has been found. The number of that column indexes a table with one slot per column. The slot returns a lookup address, or an indirect pointer to the value. A kind bit tells the two apart. Slots of columns that do not end a keyword are never read.

Software or a configuration engine writes one column at a time through the write port. Each write sets the character, the end mark and the table slot of that column. A write clears all match progress. So does the restart input, which is used at frame or packet boundaries.

Top module: `kwm_matcher`

## Requirements
- R1: After reset, hit_valid is low, all element flags are clear and every end mark is clear, so no input byte produces a hit until a keyword has been written.
- R2: A column matches only when all CHAR_W bits of the input byte equal its stored character; a byte that differs in any single bit (bit 0 or bit 7 included) does not match.
- R3: hit_valid is a one-cycle pulse in the clock cycle after the accepted byte that completes a keyword, and it is never raised for a cycle in which no byte was accepted.
- R4: A column that does not start a keyword sets its flag only if the previous column's flag was set by the previous accepted byte and its own character matches now; a non-matching byte in between breaks the keyword.
- R5: Cycles with str_valid low leave all flags unchanged and produce no hit, so a keyword may be spread across stall cycles.
- R6: Every column is evaluated on every byte, so a keyword with a repeated prefix is found inside a longer run of that prefix (keyword "aab" in stream "aaab").
- R7: When several keywords complete on the same byte, the one whose end column has the lowest number is reported.
- R8: hit_pe gives the number of the completing column, and hit_ptr and hit_ind give the table slot last written for that column; hit_ind = 0 marks a direct address and hit_ind = 1 marks an indirect pointer.
- R9: str_restart clears all flags, and a byte presented in the same cycle is discarded.
- R10: A write through the configuration port clears all flags, and a byte presented in the same cycle is discarded.
- R11: Column 0 and every column that follows an end-marked column start a keyword and set their flag on a character match alone, so adjacent keywords match independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Column write strobe |
| cfg_col | input | $clog2(NUM_COLS) | Column being written |
| cfg_char | input | CHAR_W | Character stored in the column |
| cfg_end | input | 1 | Column holds the last character of a keyword |
| cfg_ptr | input | PTR_W | Table slot value for the column |
| cfg_ind | input | 1 | Slot kind: 0 direct address, 1 indirect pointer |
| str_valid | input | 1 | Input byte is present this cycle |
| str_char | input | CHAR_W | Input byte |
| str_restart | input | 1 | Clear all match progress |
| hit_valid | output | 1 | A keyword completed on the previous accepted byte |
| hit_pe | output | $clog2(NUM_COLS) | Column where the reported keyword ends |
| hit_ptr | output | PTR_W | Table slot of that column |
| hit_ind | output | 1 | Kind bit of that slot |

## Verification
The bench goes after two keywords that finish on the same byte. A design with the wrong priority reports the longer keyword's neighbour and the wrong pointer. It feeds a repeated prefix. A design that lets one element's flag block another misses "aab" in "aaab". It inserts stall cycles inside a keyword, where a design that advanced or cleared flags on idle cycles would lose or invent hits. It also applies restart and a configuration write in mid-keyword, and sends bytes that differ from a stored character by one bit; a design that compared only part of the byte, or kept progress across a clear, would raise a false hit. A rewrite of a table slot confirms that the returned pointer follows the last write.

// File: rtl/kwm_pkg.sv
package kwm_pkg;

   // Kind of value held in one slot of the position table
   typedef enum logic {
      PTR_DIRECT   = 1'b0,
      PTR_INDIRECT = 1'b1
   } ptr_kind_e;

   localparam int KWM_DEF_COLS   = 16;
   localparam int KWM_DEF_CHAR_W = 8;
   localparam int KWM_DEF_PTR_W  = 12;

endpackage

// File: rtl/kwm_cma.sv
// Character compare array: one stored character and end mark per column,
// every column compared against the incoming byte in parallel.
module kwm_cma #(
   parameter  int NUM_COLS = kwm_pkg::KWM_DEF_COLS,
   parameter  int CHAR_W   = kwm_pkg::KWM_DEF_CHAR_W,
   localparam int IDX_W    = $clog2(NUM_COLS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_col,
   input  logic [CHAR_W-1:0]   wr_char,
   input  logic                wr_end,
   input  logic [CHAR_W-1:0]   in_char,
   output logic [NUM_COLS-1:0] col_match,
   output logic [NUM_COLS-1:0] col_first,
   output logic [NUM_COLS-1:0] col_end
);

   generate
      if (NUM_COLS < 2) begin : g_bad_cols
         $error("kwm_cma: NUM_COLS must be at least 2");
      end
      if (CHAR_W < 1) begin : g_bad_char
         $error("kwm_cma: CHAR_W must be at least 1");
      end
   endgenerate

   logic [CHAR_W-1:0] char_q [NUM_COLS];
   logic [NUM_COLS-1:0] end_q;

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic sel;
      assign sel = wr_en && (wr_col == IDX_W'(c));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            char_q[c] <= '0;
            end_q[c]  <= 1'b0;
         end else if (sel) begin
            char_q[c] <= wr_char;
            end_q[c]  <= wr_end;
         end
      end

      // bitwise difference, reduced: equal only when no bit differs
      assign col_match[c] = ~|(char_q[c] ^ in_char);

      if (c == 0) begin : g_head
         assign col_first[c] = 1'b1;
      end else begin : g_link
         assign col_first[c] = end_q[c-1];
      end
   end

   assign col_end = end_q;

endmodule

// File: rtl/kwm_pe_chain.sv
// Chain of processing elements: each keeps one flag meaning "keyword prefix
// ending at this column was seen on the last accepted byte".
module kwm_pe_chain #(
   parameter int NUM_COLS = kwm_pkg::KWM_DEF_COLS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  logic                clr,
   input  logic [NUM_COLS-1:0] col_match,
   input  logic [NUM_COLS-1:0] col_first,
   output logic [NUM_COLS-1:0] flag_nxt,
   output logic [NUM_COLS-1:0] flag_q
);

   generate
      if (NUM_COLS < 2) begin : g_bad_cols
         $error("kwm_pe_chain: NUM_COLS must be at least 2");
      end
   endgenerate

   for (genvar p = 0; p < NUM_COLS; p++) begin : g_pe
      if (p == 0) begin : g_head
         assign flag_nxt[p] = col_match[p];
      end else begin : g_body
         assign flag_nxt[p] = col_match[p] & (col_first[p] | flag_q[p-1]);

         // a continuing element may only rise behind its predecessor
         assert_chain_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flag_q[p]) && !col_first[p]) |-> $past(flag_q[p-1]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= '0;
      else if (clr)    flag_q <= '0;
      else if (adv)    flag_q <= flag_nxt;
   end

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(flag_q));

   assert_clear_flags_R9_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flag_q == '0));

endmodule

// File: rtl/kwm_lowest.sv
// Lowest-index-wins selector over the completion vector.
module kwm_lowest #(
   parameter  int N     = kwm_pkg::KWM_DEF_COLS,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   generate
      if (N < 2) begin : g_bad_n
         $error("kwm_lowest: N must be at least 2");
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

   always_comb begin
      if (any) begin
         assert_lowest_wins_R7: assert (req[idx] &&
            ((req & ((N'(1) << idx) - N'(1))) == '0));
      end
   end

endmodule

// File: rtl/kwm_map_table.sv
// One slot per column: lookup address or indirect pointer plus kind bit.
module kwm_map_table #(
   parameter  int NUM_COLS = kwm_pkg::KWM_DEF_COLS,
   parameter  int PTR_W    = kwm_pkg::KWM_DEF_PTR_W,
   localparam int IDX_W    = $clog2(NUM_COLS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_col,
   input  logic [PTR_W-1:0]    wr_ptr,
   input  kwm_pkg::ptr_kind_e  wr_kind,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [PTR_W-1:0]    rd_ptr,
   output kwm_pkg::ptr_kind_e  rd_kind
);

   generate
      if (PTR_W < 1) begin : g_bad_ptr
         $error("kwm_map_table: PTR_W must be at least 1");
      end
   endgenerate

   logic [PTR_W-1:0]   ptr_q  [NUM_COLS];
   kwm_pkg::ptr_kind_e kind_q [NUM_COLS];

   for (genvar s = 0; s < NUM_COLS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr_q[s]  <= '0;
            kind_q[s] <= kwm_pkg::PTR_DIRECT;
         end else if (wr_en && (wr_col == IDX_W'(s))) begin
            ptr_q[s]  <= wr_ptr;
            kind_q[s] <= wr_kind;
         end
      end
   end

   assign rd_ptr  = ptr_q[rd_idx];
   assign rd_kind = kind_q[rd_idx];

endmodule

// File: rtl/kwm_matcher.sv
// Top: compare array, element chain, lowest-index selection, table lookup,
// registered hit outputs one cycle after the completing byte.
module kwm_matcher #(
   parameter  int NUM_COLS = kwm_pkg::KWM_DEF_COLS,
   parameter  int CHAR_W   = kwm_pkg::KWM_DEF_CHAR_W,
   parameter  int PTR_W    = kwm_pkg::KWM_DEF_PTR_W,
   localparam int IDX_W    = $clog2(NUM_COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_col,
   input  logic [CHAR_W-1:0] cfg_char,
   input  logic              cfg_end,
   input  logic [PTR_W-1:0]  cfg_ptr,
   input  logic              cfg_ind,
   input  logic              str_valid,
   input  logic [CHAR_W-1:0] str_char,
   input  logic              str_restart,
   output logic              hit_valid,
   output logic [IDX_W-1:0]  hit_pe,
   output logic [PTR_W-1:0]  hit_ptr,
   output logic              hit_ind
);

   generate
      if (NUM_COLS < 2) begin : g_bad_cols
         $error("kwm_matcher: NUM_COLS must be at least 2");
      end
   endgenerate

   logic [NUM_COLS-1:0] col_match, col_first, col_end;
   logic [NUM_COLS-1:0] flag_nxt, flag_q, done;
   logic                clr, accept, enc_any;
   logic [IDX_W-1:0]    enc_idx;
   logic [PTR_W-1:0]    rd_ptr;
   kwm_pkg::ptr_kind_e  rd_kind;
   kwm_pkg::ptr_kind_e  wr_kind;

   assign clr     = cfg_we | str_restart;
   assign accept  = str_valid & ~clr;
   assign wr_kind = kwm_pkg::ptr_kind_e'(cfg_ind);

   kwm_cma #(.NUM_COLS(NUM_COLS), .CHAR_W(CHAR_W)) u_cma (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_col    (cfg_col),
      .wr_char   (cfg_char),
      .wr_end    (cfg_end),
      .in_char   (str_char),
      .col_match (col_match),
      .col_first (col_first),
      .col_end   (col_end)
   );

   kwm_pe_chain #(.NUM_COLS(NUM_COLS)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (str_valid),
      .clr       (clr),
      .col_match (col_match),
      .col_first (col_first),
      .flag_nxt  (flag_nxt),
      .flag_q    (flag_q)
   );

   assign done = flag_nxt & col_end & {NUM_COLS{accept}};

   kwm_lowest #(.N(NUM_COLS)) u_sel (
      .req (done),
      .any (enc_any),
      .idx (enc_idx)
   );

   kwm_map_table #(.NUM_COLS(NUM_COLS), .PTR_W(PTR_W)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_col  (cfg_col),
      .wr_ptr  (cfg_ptr),
      .wr_kind (wr_kind),
      .rd_idx  (enc_idx),
      .rd_ptr  (rd_ptr),
      .rd_kind (rd_kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_valid <= 1'b0;
         hit_pe    <= '0;
         hit_ptr   <= '0;
         hit_ind   <= 1'b0;
      end else begin
         hit_valid <= enc_any;
         if (enc_any) begin
            hit_pe  <= enc_idx;
            hit_ptr <= rd_ptr;
            hit_ind <= rd_kind;
         end
      end
   end

   // a hit is only reported for a byte that was actually taken
   assert_hit_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> $past(str_valid && !str_restart && !cfg_we));

   // the reported column must carry an end mark
   assert_hit_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> col_end[hit_pe]);

endmodule

// File: tb/sim_kwm_matcher.sv
`timescale 1ns/1ps
module sim_kwm_matcher;

   localparam int NC = 16;
   localparam int CW = 8;
   localparam int PW = 12;
   localparam int IW = $clog2(NC);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we, cfg_end, cfg_ind;
   logic [IW-1:0] cfg_col;
   logic [CW-1:0] cfg_char;
   logic [PW-1:0] cfg_ptr;
   logic          str_valid, str_restart;
   logic [CW-1:0] str_char;
   logic          hit_valid, hit_ind;
   logic [IW-1:0] hit_pe;
   logic [PW-1:0] hit_ptr;

   int n_chk  = 0;
   int n_fail = 0;

   logic [PW-1:0] exp_ptr [NC];
   logic          exp_ind [NC];

   always #2.5 clk = ~clk;

   kwm_matcher #(.NUM_COLS(NC), .CHAR_W(CW), .PTR_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_col(cfg_col), .cfg_char(cfg_char), .cfg_end(cfg_end),
      .cfg_ptr(cfg_ptr), .cfg_ind(cfg_ind),
      .str_valid(str_valid), .str_char(str_char), .str_restart(str_restart),
      .hit_valid(hit_valid), .hit_pe(hit_pe), .hit_ptr(hit_ptr), .hit_ind(hit_ind)
   );

   // vector: {req[3:0], valid, restart, char[7:0], exp_hit, exp_pe[3:0]}
   localparam int NV = 26;
   localparam logic [18:0] VEC [NV] = '{
      {4'd3,  1'b1, 1'b0, 8'h78, 1'b1, 4'd0},  // R3 single char keyword
      {4'd7,  1'b1, 1'b0, 8'h63, 1'b0, 4'd0},  // R7
      {4'd7,  1'b1, 1'b0, 8'h61, 1'b0, 4'd0},  // R7
      {4'd7,  1'b1, 1'b0, 8'h74, 1'b1, 4'd3},  // R7 "cat" and "at" together
      {4'd11, 1'b1, 1'b0, 8'h61, 1'b0, 4'd0},  // R11
      {4'd11, 1'b1, 1'b0, 8'h74, 1'b1, 4'd5},  // R11 "at" alone
      {4'd6,  1'b1, 1'b0, 8'h61, 1'b0, 4'd0},  // R6
      {4'd6,  1'b1, 1'b0, 8'h61, 1'b0, 4'd0},  // R6
      {4'd6,  1'b1, 1'b0, 8'h61, 1'b0, 4'd0},  // R6
      {4'd6,  1'b1, 1'b0, 8'h62, 1'b1, 4'd8},  // R6 "aab" inside "aaab"
      {4'd5,  1'b1, 1'b0, 8'h63, 1'b0, 4'd0},  // R5
      {4'd5,  1'b0, 1'b0, 8'h74, 1'b0, 4'd0},  // R5 idle byte ignored
      {4'd5,  1'b1, 1'b0, 8'h61, 1'b0, 4'd0},  // R5
      {4'd5,  1'b0, 1'b0, 8'h00, 1'b0, 4'd0},  // R5 idle
      {4'd5,  1'b1, 1'b0, 8'h74, 1'b1, 4'd3},  // R5 keyword across stalls
      {4'd9,  1'b1, 1'b0, 8'h63, 1'b0, 4'd0},  // R9
      {4'd9,  1'b1, 1'b0, 8'h61, 1'b0, 4'd0},  // R9
      {4'd9,  1'b1, 1'b1, 8'h74, 1'b0, 4'd0},  // R9 restart drops byte
      {4'd9,  1'b1, 1'b0, 8'h74, 1'b0, 4'd0},  // R9 progress gone
      {4'd2,  1'b1, 1'b0, 8'h79, 1'b0, 4'd0},  // R2 bit 0 differs
      {4'd4,  1'b1, 1'b0, 8'h63, 1'b0, 4'd0},  // R4
      {4'd2,  1'b1, 1'b0, 8'hE1, 1'b0, 4'd0},  // R2 bit 7 differs
      {4'd4,  1'b1, 1'b0, 8'h74, 1'b0, 4'd0},  // R4 chain broken
      {4'd4,  1'b1, 1'b0, 8'h63, 1'b0, 4'd0},  // R4
      {4'd3,  1'b1, 1'b0, 8'h78, 1'b1, 4'd0},  // R3
      {4'd4,  1'b1, 1'b0, 8'h74, 1'b0, 4'd0}   // R4 broken by other byte
   };

   function automatic string rtag(input logic [3:0] r);
      case (r)
         4'd1:  return "R1";
         4'd2:  return "R2";
         4'd3:  return "R3";
         4'd4:  return "R4";
         4'd5:  return "R5";
         4'd6:  return "R6";
         4'd7:  return "R7";
         4'd8:  return "R8";
         4'd9:  return "R9";
         4'd10: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      cfg_we = 1'b0; cfg_col = '0; cfg_char = '0; cfg_end = 1'b0;
      cfg_ptr = '0; cfg_ind = 1'b0;
      str_valid = 1'b0; str_restart = 1'b0; str_char = '0;
   endtask

   task automatic cfg_write(input int col, input logic [7:0] ch, input logic e,
                            input logic [PW-1:0] p, input logic ind);
      @(negedge clk);
      idle_inputs();
      cfg_we = 1'b1; cfg_col = IW'(col); cfg_char = ch; cfg_end = e;
      cfg_ptr = p; cfg_ind = ind;
      exp_ptr[col] = p; exp_ind[col] = ind;
      @(posedge clk); #1;
   endtask

   // drive one stream cycle; outputs sampled 1 ns after the edge that takes it
   task automatic send(input logic v, input logic rs, input logic [7:0] ch);
      @(negedge clk);
      idle_inputs();
      str_valid = v; str_restart = rs; str_char = ch;
      @(posedge clk); #1;
   endtask

   task automatic expect_hit(input string req, input int pe);
      chk(req, "hit_valid", int'(hit_valid), 1);
      chk(req, "hit_pe", int'(hit_pe), pe);
      chk(req, "hit_ptr", int'(hit_ptr), int'(exp_ptr[pe]));
      chk(req, "hit_ind", int'(hit_ind), int'(exp_ind[pe]));
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NC; i++) begin
         exp_ptr[i] = '0;
         exp_ind[i] = 1'b0;
      end
      idle_inputs();
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "hit_valid after reset", int'(hit_valid), 0);

      // R1: nothing is stored, a zero byte matches every column but no end mark exists
      send(1'b1, 1'b0, 8'h00);
      chk("R1", "hit_valid zero byte", int'(hit_valid), 0);
      send(1'b1, 1'b0, 8'h00);
      chk("R1", "hit_valid second zero byte", int'(hit_valid), 0);

      // keyword set: "x"@0, "cat"@1..3, "at"@4..5, "aab"@6..8
      cfg_write(0, 8'h78, 1'b1, 12'h100, 1'b0);
      cfg_write(1, 8'h63, 1'b0, 12'h0A1, 1'b0);
      cfg_write(2, 8'h61, 1'b0, 12'h0A2, 1'b0);
      cfg_write(3, 8'h74, 1'b1, 12'h033, 1'b1);
      cfg_write(4, 8'h61, 1'b0, 12'h0A4, 1'b0);
      cfg_write(5, 8'h74, 1'b1, 12'h055, 1'b0);
      cfg_write(6, 8'h61, 1'b0, 12'h0A6, 1'b0);
      cfg_write(7, 8'h61, 1'b0, 12'h0A7, 1'b0);
      cfg_write(8, 8'h62, 1'b1, 12'h088, 1'b1);

      for (int v = 0; v < NV; v++) begin
         logic [18:0] w;
         w = VEC[v];
         send(w[14], w[13], w[12:5]);
         if (w[4]) expect_hit(rtag(w[18:15]), int'(w[3:0]));
         else      chk(rtag(w[18:15]), "hit_valid", int'(hit_valid), 0);
      end

      // R3: the pulse lasts one cycle only
      send(1'b1, 1'b0, 8'h78);
      expect_hit("R3", 0);
      send(1'b0, 1'b0, 8'h00);
      chk("R3", "hit_valid pulse end", int'(hit_valid), 0);

      // R10: a write in mid keyword clears progress
      send(1'b1, 1'b0, 8'h63);
      send(1'b1, 1'b0, 8'h61);
      cfg_write(12, 8'hEE, 1'b0, 12'h0CC, 1'b0);
      chk("R10", "hit_valid write cycle", int'(hit_valid), 0);
      send(1'b1, 1'b0, 8'h74);
      chk("R10", "hit_valid after write", int'(hit_valid), 0);

      // R10: byte presented together with a write is discarded
      @(negedge clk);
      idle_inputs();
      cfg_we = 1'b1; cfg_col = IW'(13); cfg_char = 8'hDD; cfg_ptr = 12'h0DD;
      exp_ptr[13] = 12'h0DD; exp_ind[13] = 1'b0;
      str_valid = 1'b1; str_char = 8'h78;
      @(posedge clk); #1;
      chk("R10", "hit_valid byte with write", int'(hit_valid), 0);

      // R8: rewriting a slot changes the returned pointer and kind
      cfg_write(0, 8'h78, 1'b1, 12'hABC, 1'b1);
      send(1'b1, 1'b0, 8'h78);
      expect_hit("R8", 0);
      send(1'b1, 1'b0, 8'h63);
      send(1'b1, 1'b0, 8'h61);
      send(1'b1, 1'b0, 8'h74);
      expect_hit("R8", 3);

      send(1'b0, 1'b0, 8'h00);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule